// File: doc/BRIEF.md
# Fifth-Order CIC Decimator with Selectable Ratio

This block is the first decimation stage behind a multibit sigma-delta modulator. Each accepted input is a 5-bit two's-complement word. The block runs five integrators at the input rate and, once per output period, five first-difference combs. Its response is a sinc^5 filter followed by downsampling. The output goes to a chain of three decimate-by-two half-band stages. For that reason the output rate is eight times the final sample rate in both rate modes.

A single select input picks the ratio. Normal-rate mode divides by 16, which turns a 128x input stream into 8x. Double-rate mode divides by 8, which turns a 64x input stream into 8x. The output is given at full accumulator width and is never scaled. A separate port reports the power of two of the DC gain, so that a later stage can normalise the result.

Arithmetic wraps modulo 2^25. The ratio select is registered. When the select differs from the registered mode, the filter flushes: it clears its state and suppresses output until the combs hold only post-change history.

Top module: `cic5_decimator`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `out_valid` is 0, `out_data` is 0 and `gain_shift` is 20.
- R2: With `rate_sel` = 0, the ratio is 16. `out_valid` rises in the cycle after every 16th accepted input (an input is accepted when `in_valid` = 1 and there is no mode change in that cycle).
- R3: With `rate_sel` = 1, the ratio is 8. `out_valid` rises in the cycle after every 8th accepted input.
- R4: Whenever `out_valid` is 1, `out_data` equals the sum over k of h[k]·x[n-k]. Here x[n] is the accepted input that completed the period, and h holds the coefficients of (1 + z^-1 + … + z^-(R-1))^5. Inputs from before the last reset or flush count as zero.
- R5: A cycle with `in_valid` = 0 changes no filter state, and it is never followed by `out_valid` = 1.
- R6: `out_valid` lasts exactly one cycle. While it is 0, `out_data` holds its last value.
- R7: In a cycle where `rate_sel` differs from the registered mode, that cycle's input is discarded, the integrators, combs and period counter are cleared, and the new mode is taken. The next five period completions give no `out_valid`.
- R8: After reset, the first five period completions also give no `out_valid`. The sixth is the first output.
- R9: `gain_shift` is 20 in normal-rate mode and 15 in double-rate mode. It follows the registered mode, which means the value of `rate_sel` from one cycle earlier.
- R10: `in_data` is read as two's complement (bit 4 is the sign). A constant full-scale input of -16 gives exactly -16·R^5 at full width, and +15 gives 15·R^5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Modulator word strobe |
| in_data | input | 5 | Modulator word, two's complement |
| rate_sel | input | 1 | 0: ratio 16, 1: ratio 8 |
| out_valid | output | 1 | One-cycle strobe for a decimated sample |
| out_data | output | 25 | Full-width decimated sample, two's complement |
| gain_shift | output | 5 | log2 of the DC gain for the active mode |

## Verification
The bench builds the block with its default values: a 5-bit input, fifth order, and ratios of 16 and 8. The accumulator is then 25 bits, wide enough that every full-scale output is exact. With this setup the bench sweeps all 32 input codes as held levels in both modes, and it also runs an impulse and long pseudo-random streams with gaps in the strobe. Each output is compared with a direct convolution against sinc^5 coefficients that the bench builds by repeated box convolution. Mode changes happen both during idle cycles and on a strobed cycle, which exercises the discard and the five-period suppression.

// File: rtl/cic5_pkg.sv
package cic5_pkg;

    typedef enum logic {
        RATE_NORMAL = 1'b0,
        RATE_DOUBLE = 1'b1
    } rate_e;

    // Growth bound: input width plus one ratio exponent per stage.
    function automatic int acc_width(input int in_w, input int order, input int rlog);
        return in_w + order * rlog;
    endfunction

endpackage

// File: rtl/cic5_integrators.sv
module cic5_integrators #(
    parameter int IN_W  = 5,
    parameter int ORDER = 5,
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [IN_W-1:0]  din,
    output logic [ACC_W-1:0] sum_o
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_state_t;

    integ_state_t st_d, st_q;
    logic [ORDER-1:0][ACC_W-1:0] chain;

    always_comb begin
        logic [ACC_W-1:0] feed;
        feed = {{(ACC_W-IN_W){din[IN_W-1]}}, din};
        for (int k = 0; k < ORDER; k++) begin
            chain[k] = st_q.acc[k] + feed;
            feed     = chain[k];
        end
        st_d = st_q;
        if (clear)
            st_d = '0;
        else if (en)
            st_d.acc = chain;
        sum_o = chain[ORDER-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/cic5_combs.sv
module cic5_combs #(
    parameter int ORDER = 5,
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
    } comb_state_t;

    comb_state_t st_d, st_q;
    logic [ORDER-1:0][ACC_W-1:0] tap_in;

    always_comb begin
        logic [ACC_W-1:0] stage;
        stage = din;
        for (int k = 0; k < ORDER; k++) begin
            tap_in[k] = stage;
            stage     = stage - st_q.dly[k];
        end
        st_d = st_q;
        if (clear)
            st_d = '0;
        else if (en)
            st_d.dly = tap_in;
        dout = stage;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/cic5_sequencer.sv
module cic5_sequencer #(
    parameter int ORDER   = 5,
    parameter int RLOG_HI = 4,
    parameter int RLOG_LO = 3,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               rate_sel,
    output logic               clear,
    output logic               accept,
    output logic               dump,
    output logic               emit,
    output logic [SHIFT_W-1:0] gain_shift
);

    import cic5_pkg::*;

    localparam int CNT_W  = RLOG_HI;
    localparam int HOLD_W = $clog2(ORDER + 1);

    typedef struct packed {
        rate_e             mode;
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;
    logic             at_last;

    always_comb begin
        last_idx = (st_q.mode == RATE_DOUBLE) ? CNT_W'((1 << RLOG_LO) - 1)
                                               : CNT_W'((1 << RLOG_HI) - 1);
        at_last  = (st_q.cnt == last_idx);
        clear    = (rate_e'(rate_sel) != st_q.mode);
        accept   = in_valid && !clear;
        dump     = accept && at_last;
        emit     = dump && (st_q.hold == '0);

        st_d      = st_q;
        st_d.mode = rate_e'(rate_sel);
        if (clear) begin
            st_d.cnt  = '0;
            st_d.hold = HOLD_W'(ORDER);
        end else if (accept) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
            if (dump && st_q.hold != '0)
                st_d.hold = st_q.hold - 1'b1;
        end

        gain_shift = (st_q.mode == RATE_DOUBLE) ? SHIFT_W'(ORDER * RLOG_LO)
                                                 : SHIFT_W'(ORDER * RLOG_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= RATE_NORMAL;
            st_q.cnt  <= '0;
            st_q.hold <= HOLD_W'(ORDER);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cic5_decimator.sv
module cic5_decimator #(
    parameter  int IN_W    = 5,
    parameter  int ORDER   = 5,
    parameter  int RLOG_HI = 4,
    parameter  int RLOG_LO = 3,
    localparam int ACC_W   = cic5_pkg::acc_width(IN_W, ORDER, RLOG_HI),
    localparam int SHIFT_W = $clog2(ORDER * RLOG_HI + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_data,
    input  logic               rate_sel,
    output logic               out_valid,
    output logic [ACC_W-1:0]   out_data,
    output logic [SHIFT_W-1:0] gain_shift
);

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] dat;
    } out_state_t;

    out_state_t       st_d, st_q;
    logic             seq_clear, seq_accept, seq_dump, seq_emit;
    logic [ACC_W-1:0] integ_sum, comb_out;

    cic5_sequencer #(
        .ORDER  (ORDER),
        .RLOG_HI(RLOG_HI),
        .RLOG_LO(RLOG_LO),
        .SHIFT_W(SHIFT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .rate_sel  (rate_sel),
        .clear     (seq_clear),
        .accept    (seq_accept),
        .dump      (seq_dump),
        .emit      (seq_emit),
        .gain_shift(gain_shift)
    );

    cic5_integrators #(
        .IN_W (IN_W),
        .ORDER(ORDER),
        .ACC_W(ACC_W)
    ) u_integ (
        .clk  (clk),
        .rst  (rst),
        .clear(seq_clear),
        .en   (seq_accept),
        .din  (in_data),
        .sum_o(integ_sum)
    );

    cic5_combs #(
        .ORDER(ORDER),
        .ACC_W(ACC_W)
    ) u_comb (
        .clk  (clk),
        .rst  (rst),
        .clear(seq_clear),
        .en   (seq_dump),
        .din  (integ_sum),
        .dout (comb_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = seq_emit;
        if (seq_emit)
            st_d.dat = comb_out;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

endmodule

// File: rtl/cic5_decimator_chk.sv
module cic5_decimator_chk #(
    parameter int ORDER   = 5,
    parameter int RLOG_HI = 4,
    parameter int RLOG_LO = 3,
    parameter int ACC_W   = 25,
    parameter int SHIFT_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               rate_sel,
    input logic               out_valid,
    input logic [ACC_W-1:0]   out_data,
    input logic [SHIFT_W-1:0] gain_shift
);

    localparam logic [SHIFT_W-1:0] SH_NORM = SHIFT_W'(ORDER * RLOG_HI);
    localparam logic [SHIFT_W-1:0] SH_DBL  = SHIFT_W'(ORDER * RLOG_LO);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    assert_idle_no_output_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |=> !out_valid);

    assert_shift_follows_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (gain_shift == ($past(rate_sel) ? SH_DBL : SH_NORM)));

    always_comb begin
        if (!rst)
            assert_shift_legal_R9: assert (gain_shift == SH_NORM || gain_shift == SH_DBL);
    end

endmodule

bind cic5_decimator cic5_decimator_chk #(
    .ORDER  (ORDER),
    .RLOG_HI(RLOG_HI),
    .RLOG_LO(RLOG_LO),
    .ACC_W  (ACC_W),
    .SHIFT_W(SHIFT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rate_sel  (rate_sel),
    .out_valid (out_valid),
    .out_data  (out_data),
    .gain_shift(gain_shift)
);

// File: tb/cic5_decimator_bench.sv
module cic5_decimator_bench;

    localparam int ACC_W  = 25;
    localparam int HMAX   = 80;
    localparam int HISTSZ = 8192;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [4:0]        in_data = '0;
    logic              rate_sel = 1'b0;
    logic              out_valid;
    logic [ACC_W-1:0]  out_data;
    logic [4:0]        gain_shift;

    int     checks = 0;
    int     errors = 0;
    bit     done   = 0;

    longint hc [0:1][0:HMAX-1];
    int     hist [0:HISTSZ-1];
    int     n_acc;
    int     cur_mode;
    bit     since_reset;
    logic [ACC_W-1:0] prev_out;

    always #10 clk = ~clk;

    cic5_decimator u_cic5_decimator (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .rate_sel  (rate_sel),
        .out_valid (out_valid),
        .out_data  (out_data),
        .gain_shift(gain_shift)
    );

    // sinc^5 taps by five box convolutions
    initial begin
        for (int m = 0; m < 2; m++) begin
            longint cur [0:HMAX-1];
            longint tmp [0:HMAX-1];
            int r;
            int len;
            r = (m == 1) ? 8 : 16;
            for (int i = 0; i < HMAX; i++) cur[i] = 0;
            cur[0] = 1;
            len = 1;
            for (int s = 0; s < 5; s++) begin
                for (int i = 0; i < HMAX; i++) tmp[i] = 0;
                for (int i = 0; i < len; i++)
                    for (int j = 0; j < r; j++)
                        tmp[i+j] += cur[i];
                len += r - 1;
                for (int i = 0; i < HMAX; i++) cur[i] = tmp[i];
            end
            for (int i = 0; i < HMAX; i++) hc[m][i] = cur[i];
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_sum(input int m, input int n);
        longint s;
        int r;
        s = 0;
        r = (m == 1) ? 8 : 16;
        for (int k = 0; k <= 5 * (r - 1); k++)
            if (n - 1 - k >= 0)
                s += hc[m][k] * longint'(hist[n-1-k]);
        return s;
    endfunction

    task automatic step(input bit v, input int x, input bit sel);
        bit     exp_vld;
        longint exp_dat;
        int     r;
        in_valid = v;
        in_data  = x[4:0];
        rate_sel = sel;
        exp_vld  = 0;
        exp_dat  = 0;
        if (int'(sel) != cur_mode) begin
            cur_mode    = int'(sel);
            n_acc       = 0;
            since_reset = 0;
        end else if (v) begin
            hist[n_acc] = x;
            n_acc++;
            r = (cur_mode == 1) ? 8 : 16;
            if (n_acc % r == 0 && n_acc / r > 5) begin
                exp_vld = 1;
                exp_dat = expect_sum(cur_mode, n_acc);
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (exp_vld)
            check(out_valid == 1'b1, cur_mode == 1 ? "R3" : "R2", longint'(out_valid), 1);
        else
            check(out_valid == 1'b0, since_reset ? "R8 R5" : "R7 R5", longint'(out_valid), 0);
        if (exp_vld)
            check(longint'($signed(out_data)) == exp_dat, "R4 R10",
                  longint'($signed(out_data)), exp_dat);
        else
            check(out_data == prev_out, "R6", longint'($signed(out_data)),
                  longint'($signed(prev_out)));
        check(gain_shift == ((cur_mode == 1) ? 5'd15 : 5'd20), "R9",
              longint'(gain_shift), (cur_mode == 1) ? 15 : 20);
        prev_out = out_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        cur_mode    = 0;
        n_acc       = 0;
        since_reset = 1;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(out_data == '0, "R1", longint'(out_data), 0);
        check(gain_shift == 5'd20, "R1", longint'(gain_shift), 20);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1", longint'(out_data), 0);
        prev_out = out_data;

        // R2 R4 R10: every code held for 8 periods, ratio 16
        for (int c = -16; c < 16; c++)
            for (int i = 0; i < 128; i++)
                step(1, c, 0);

        // R7: mode change during idle, then R3 sweep at ratio 8
        step(0, 0, 1);
        for (int c = 15; c >= -16; c--)
            for (int i = 0; i < 64; i++)
                step(1, c, 1);

        // R5: random stream with strobe gaps, ratio 8
        for (int i = 0; i < 3000; i++) begin
            int rv;
            rv = int'($urandom_range(0, 3));
            if (rv == 0) step(0, int'($urandom_range(0, 31)) - 16, 1);
            step(1, int'($urandom_range(0, 31)) - 16, 1);
        end

        // R7: mode change on a strobed cycle (input discarded), ratio 16
        step(1, 15, 0);
        for (int i = 0; i < 3000; i++) begin
            int rv;
            rv = int'($urandom_range(0, 4));
            if (rv == 0) step(0, 7, 0);
            step(1, int'($urandom_range(0, 31)) - 16, 0);
        end

        // R4: impulse response at ratio 8 after a flush
        step(0, 0, 1);
        for (int i = 0; i < 60; i++) step(1, 0, 1);
        step(1, 1, 1);
        for (int i = 0; i < 80; i++) step(1, 0, 1);

        // R10: full-scale extremes at ratio 8
        for (int i = 0; i < 64; i++) step(1, -16, 1);
        check(longint'($signed(out_data)) == -16 * 32768, "R10",
              longint'($signed(out_data)), -16 * 32768);
        for (int i = 0; i < 64; i++) step(1, 15, 1);
        check(longint'($signed(out_data)) == 15 * 32768, "R10",
              longint'($signed(out_data)), 15 * 32768);

        finish_run();
    end

endmodule